// File: doc/BRIEF.md
# Write-Protect Command Sequencer

This block watches the stream of byte loads headed for a nonvolatile page buffer and keeps one write-protect flag. Two keyed command sequences are recognized, each a fixed run of data bytes at fixed addresses. The first is a three-load prefix. It turns protection on, and it is also the key that lets one protected page load through. The second is a six-load sequence that turns protection off. The block does not store anything itself. In the same cycle as each load it tells the page buffer whether that load is a command byte to swallow, a data byte to keep, or a rejected load that only starts the programming timer.

The block carries its own copy of the inter-load window. A load period stays open while loads keep arriving within `LOAD_GAP` cycles of each other. When the window closes, any partial sequence is dropped and any authorization is withdrawn. A change of protection is only pending until the external timer signals the end of the programming period on `prog_done`, and it is applied then. Reset models the shipped state given by `PROT_INIT`. After reset, only the two sequences can change the flag.

Top module: `wp_cmd_sequencer`

## Requirements
- R1: After reset, `protect_on` equals `PROT_INIT` (default 0), `wr_kind` is 2'b00 (none) while no load is offered, and `load_closed` is low.
- R2: The loads 8'hAA at 15'h5555, 8'h55 at 15'h2AAA and 8'hA0 at 15'h5555, in that order, are each classed 2'b01 (command). Protection is then set in the cycle after the next `prog_done` pulse, even if no data follows.
- R3: The loads AA@5555, 55@2AAA, 80@5555, AA@5555, 55@2AAA, 20@5555 are each classed command. Protection is cleared in the cycle after the next `prog_done`, and loads after the sequence in the same period are classed 2'b10 (data).
- R4: Command addresses are compared on address bits 14..0 only, and command data on bits 7..0. Higher address bits do not affect recognition.
- R5: While protected, a load that is neither part of a sequence nor covered by the prefix is classed 2'b11 (reject). After a completed prefix, the loads of that period are classed data.
- R6: While unprotected, a load that is not part of a command sequence is classed data.
- R7: A load that breaks a partial sequence returns the sequencer to its idle step. That load is classed data if unprotected or reject if protected, and the sequence must start again from its first byte.
- R8: `load_closed` pulses for one cycle in the `LOAD_GAP`-th idle cycle after the last load. A load in that cycle keeps the window open. Closing drops any partial sequence and ends authorization.
- R9: `protect_on` changes only in the cycle after a `prog_done` pulse. Rejected loads and window closes leave it unchanged.
- R10: Once a prefix or disable sequence has completed, every later load of that period is classed data, even one that matches a command pattern.
- R11: When `prog_done` falls in the same cycle as a load, that load is classed against the protection state before the update. A sequence completed in that cycle stays pending until the following `prog_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, restores the shipped state |
| wr_valid | input | 1 | A byte load is offered this cycle |
| wr_addr | input | ADDR_W | Load address |
| wr_data | input | DATA_W | Load data |
| prog_done | input | 1 | End of the programming period (one-cycle pulse) |
| wr_kind | output | 2 | Load class: 00 none, 01 command, 10 data, 11 reject |
| protect_on | output | 1 | Write-protect flag |
| load_closed | output | 1 | Load window expired this cycle |

## Verification
The collision of interest is the end of a programming period meeting a new load. In that cycle the protection update and the classification of the load happen together. The bench provokes this twice. First it pulses `prog_done` with a pending arm while an unkeyed load is offered. The load must come out as data, and a later load in the same period must come out as reject. Second, it places the last disable byte in the same cycle as a `prog_done` that has nothing pending. Protection must stay set in the next cycle and must clear only at the next pulse. A second timing meeting, a load landing exactly in the cycle the window would expire, is judged by `load_closed` staying low and the partial sequence still advancing.

// File: rtl/wp_seq_pkg.sv
package wp_seq_pkg;

   // Number of address bits used for command comparison and command data width.
   localparam int CMD_AW = 15;
   localparam int CMD_DW = 8;

   // Load classification presented to the page buffer.
   typedef enum logic [1:0] {
      WK_NONE   = 2'b00,
      WK_CMD    = 2'b01,
      WK_DATA   = 2'b10,
      WK_REJECT = 2'b11
   } wr_kind_e;

   // Distinct command byte patterns.
   localparam int PAT_N     = 5;
   localparam int P_KEY_A   = 0;   // AA at 5555
   localparam int P_KEY_B   = 1;   // 55 at 2AAA
   localparam int P_ARM     = 2;   // A0 at 5555
   localparam int P_DIS_PRE = 3;   // 80 at 5555
   localparam int P_DIS_END = 4;   // 20 at 5555

   // Sequencer progress through the two command sequences.
   typedef enum logic [2:0] {
      SQ_IDLE  = 3'd0,
      SQ_KA    = 3'd1,
      SQ_KB    = 3'd2,
      SQ_DPRE  = 3'd3,
      SQ_DKA   = 3'd4,
      SQ_DKB   = 3'd5
   } seq_step_e;

   function automatic logic [CMD_AW-1:0] pat_addr(input int idx);
      case (idx)
         P_KEY_B: pat_addr = 15'h2AAA;
         default: pat_addr = 15'h5555;
      endcase
   endfunction

   function automatic logic [CMD_DW-1:0] pat_data(input int idx);
      case (idx)
         P_KEY_A:   pat_data = 8'hAA;
         P_KEY_B:   pat_data = 8'h55;
         P_ARM:     pat_data = 8'hA0;
         P_DIS_PRE: pat_data = 8'h80;
         default:   pat_data = 8'h20;
      endcase
   endfunction

endpackage

// File: rtl/wp_cmd_decode.sv
module wp_cmd_decode
   import wp_seq_pkg::*;
#(
   parameter int ADDR_W = 17,
   parameter int DATA_W = 8
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] data,
   output logic [PAT_N-1:0]  hit
);

   if (ADDR_W < CMD_AW) begin : g_bad_aw
      $error("wp_cmd_decode: ADDR_W must cover the command address bits");
   end
   if (DATA_W < CMD_DW) begin : g_bad_dw
      $error("wp_cmd_decode: DATA_W must cover the command data bits");
   end

   logic [CMD_AW-1:0] cmp_addr;
   logic [CMD_DW-1:0] cmp_data;

   assign cmp_addr = addr[CMD_AW-1:0];
   assign cmp_data = data[CMD_DW-1:0];

   // Bits above the compared fields take no part in recognition.
   if (ADDR_W > CMD_AW) begin : g_addr_hi
      logic unused_addr_hi;
      assign unused_addr_hi = ^addr[ADDR_W-1:CMD_AW];
   end
   if (DATA_W > CMD_DW) begin : g_data_hi
      logic unused_data_hi;
      assign unused_data_hi = ^data[DATA_W-1:CMD_DW];
   end

   for (genvar p = 0; p < PAT_N; p++) begin : g_pat
      assign hit[p] = (cmp_addr == pat_addr(p)) && (cmp_data == pat_data(p));
   end

endmodule

// File: rtl/wp_load_window.sv
module wp_load_window #(
   parameter int LOAD_GAP = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_valid,
   output logic closed
);

   if (LOAD_GAP < 2) begin : g_bad_gap
      $error("wp_load_window: LOAD_GAP must be at least 2");
   end

   localparam int CNT_W = (LOAD_GAP > 2) ? $clog2(LOAD_GAP) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(LOAD_GAP - 1);

   logic             open_q;
   logic [CNT_W-1:0] idle_q;

   assign closed = open_q && !wr_valid && (idle_q == LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         open_q <= 1'b0;
         idle_q <= '0;
      end else if (wr_valid) begin
         open_q <= 1'b1;
         idle_q <= '0;
      end else if (closed) begin
         open_q <= 1'b0;
         idle_q <= '0;
      end else if (open_q) begin
         idle_q <= idle_q + 1'b1;
      end
   end

   assert_close_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      closed |=> !closed);
   assert_load_restarts_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |=> !closed);

endmodule

// File: rtl/wp_protect_flag.sv
module wp_protect_flag #(
   parameter bit PROT_INIT = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_set,
   input  logic clr_set,
   input  logic prog_done,
   output logic prot
);

   logic pend_arm_q;
   logic pend_clr_q;
   logic prot_q;

   assign prot = prot_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_arm_q <= 1'b0;
         pend_clr_q <= 1'b0;
         prot_q     <= PROT_INIT;
      end else begin
         // Pending requests retire on prog_done; requests raised in the
         // same cycle wait for the following period end.
         pend_arm_q <= (pend_arm_q && !prog_done) || arm_set;
         pend_clr_q <= (pend_clr_q && !prog_done) || clr_set;
         if (prog_done) begin
            if (pend_arm_q)      prot_q <= 1'b1;
            else if (pend_clr_q) prot_q <= 1'b0;
         end
      end
   end

   assert_prot_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !prog_done |=> $stable(prot_q));
   assert_arm_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_done && pend_arm_q) |=> prot_q);
   assert_clr_applies_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (prog_done && pend_clr_q && !pend_arm_q) |=> !prot_q);
   assert_single_request_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(arm_set && clr_set));

endmodule

// File: rtl/wp_cmd_sequencer.sv
module wp_cmd_sequencer
   import wp_seq_pkg::*;
#(
   parameter int ADDR_W    = 17,
   parameter int DATA_W    = 8,
   parameter int LOAD_GAP  = 8,
   parameter bit PROT_INIT = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              prog_done,
   output logic [1:0]        wr_kind,
   output logic              protect_on,
   output logic              load_closed
);

   logic [PAT_N-1:0] hit;
   seq_step_e        step_q, step_d;
   logic             auth_q, auth_d;
   logic             advance;
   logic             arm_set, clr_set;
   wr_kind_e         kind;

   wp_cmd_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) decode_i (
      .addr (wr_addr),
      .data (wr_data),
      .hit  (hit)
   );

   wp_load_window #(.LOAD_GAP(LOAD_GAP)) window_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_valid (wr_valid),
      .closed   (load_closed)
   );

   wp_protect_flag #(.PROT_INIT(PROT_INIT)) flag_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .arm_set   (arm_set),
      .clr_set   (clr_set),
      .prog_done (prog_done),
      .prot      (protect_on)
   );

   // Next expected command byte for the current step.
   always_comb begin
      advance = 1'b0;
      step_d  = SQ_IDLE;
      arm_set = 1'b0;
      clr_set = 1'b0;
      case (step_q)
         SQ_IDLE: begin advance = hit[P_KEY_A]; step_d = SQ_KA; end
         SQ_KA:   begin advance = hit[P_KEY_B]; step_d = SQ_KB; end
         SQ_KB: begin
            if (hit[P_ARM]) begin
               advance = 1'b1;
               step_d  = SQ_IDLE;
               arm_set = wr_valid && !auth_q;
            end else if (hit[P_DIS_PRE]) begin
               advance = 1'b1;
               step_d  = SQ_DPRE;
            end
         end
         SQ_DPRE: begin advance = hit[P_KEY_A]; step_d = SQ_DKA; end
         SQ_DKA:  begin advance = hit[P_KEY_B]; step_d = SQ_DKB; end
         SQ_DKB: begin
            advance = hit[P_DIS_END];
            step_d  = SQ_IDLE;
            clr_set = wr_valid && !auth_q && hit[P_DIS_END];
         end
         default: advance = 1'b0;
      endcase
      if (!advance) step_d = SQ_IDLE;
   end

   always_comb begin
      if (!wr_valid)    kind = WK_NONE;
      else if (auth_q)  kind = WK_DATA;
      else if (advance) kind = WK_CMD;
      else if (protect_on) kind = WK_REJECT;
      else              kind = WK_DATA;
   end

   assign wr_kind = kind;

   always_comb begin
      auth_d = auth_q;
      if (load_closed)               auth_d = 1'b0;
      else if (arm_set || clr_set)   auth_d = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         step_q <= SQ_IDLE;
         auth_q <= 1'b0;
      end else begin
         auth_q <= auth_d;
         if (load_closed)                 step_q <= SQ_IDLE;
         else if (wr_valid && !auth_q)    step_q <= step_d;
      end
   end

   assert_reject_needs_prot_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WK_REJECT) |-> protect_on);
   assert_auth_never_rejects_R10: assert property (@(posedge clk) disable iff (!rst_n)
      auth_q |-> (wr_kind != WK_REJECT));
   assert_cmd_progress_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_kind == WK_CMD) |=> ((step_q != SQ_IDLE) || auth_q));
   assert_close_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load_closed |=> ((step_q == SQ_IDLE) && !auth_q));
   assert_pattern_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit));
   assert_idle_no_kind_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_valid |-> (wr_kind == WK_NONE));

endmodule

// File: tb/wp_cmd_sequencer_tb.sv
module wp_cmd_sequencer_tb_top;

   localparam int CLK_PERIOD = 10;
   localparam int GAP        = 8;

   localparam logic [1:0] OP_WR   = 2'd0;
   localparam logic [1:0] OP_GAP  = 2'd1;
   localparam logic [1:0] OP_DONE = 2'd2;

   localparam logic [1:0] K_NONE = 2'b00;
   localparam logic [1:0] K_CMD  = 2'b01;
   localparam logic [1:0] K_DAT  = 2'b10;
   localparam logic [1:0] K_REJ  = 2'b11;

   localparam int NVEC = 47;
   // {op, addr, data, expected kind, expected protect after the step}
   localparam logic [29:0] VEC [0:NVEC-1] = '{
      {OP_WR,   17'h00123, 8'h5A, K_DAT,  1'b0},  // R6
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b0},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b0},
      {OP_WR,   17'h05555, 8'hAA, K_CMD,  1'b0},  // R2
      {OP_WR,   17'h02AAA, 8'h55, K_CMD,  1'b0},
      {OP_WR,   17'h05555, 8'hA0, K_CMD,  1'b0},
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b0},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b1},  // R2 no data
      {OP_WR,   17'h00040, 8'h11, K_REJ,  1'b1},  // R5
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b1},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b1},  // R9
      {OP_WR,   17'h15555, 8'hAA, K_CMD,  1'b1},  // R4
      {OP_WR,   17'h1AAAA, 8'h55, K_CMD,  1'b1},
      {OP_WR,   17'h0D555, 8'hA0, K_CMD,  1'b1},
      {OP_WR,   17'h00200, 8'h33, K_DAT,  1'b1},  // R5
      {OP_WR,   17'h05555, 8'hAA, K_DAT,  1'b1},  // R10
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b1},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b1},
      {OP_WR,   17'h05555, 8'hAA, K_CMD,  1'b1},  // R3
      {OP_WR,   17'h02AAA, 8'h55, K_CMD,  1'b1},
      {OP_WR,   17'h05555, 8'h80, K_CMD,  1'b1},
      {OP_WR,   17'h05555, 8'hAA, K_CMD,  1'b1},
      {OP_WR,   17'h02AAA, 8'h55, K_CMD,  1'b1},
      {OP_WR,   17'h05555, 8'h20, K_CMD,  1'b1},
      {OP_WR,   17'h00300, 8'h77, K_DAT,  1'b1},
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b1},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b0},
      {OP_WR,   17'h05555, 8'hAA, K_CMD,  1'b0},  // R7
      {OP_WR,   17'h02AAA, 8'h56, K_DAT,  1'b0},
      {OP_WR,   17'h05555, 8'hA0, K_DAT,  1'b0},
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b0},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b0},
      {OP_WR,   17'h05555, 8'hAA, K_CMD,  1'b0},  // R8 abort
      {OP_WR,   17'h02AAA, 8'h55, K_CMD,  1'b0},
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b0},
      {OP_WR,   17'h05555, 8'hA0, K_DAT,  1'b0},
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b0},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b0},
      {OP_WR,   17'h05555, 8'hAA, K_CMD,  1'b0},
      {OP_WR,   17'h02AAA, 8'h55, K_CMD,  1'b0},
      {OP_WR,   17'h05555, 8'hA0, K_CMD,  1'b0},
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b0},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b1},
      {OP_WR,   17'h05555, 8'hAA, K_CMD,  1'b1},  // R7 protected
      {OP_WR,   17'h02AAA, 8'h00, K_REJ,  1'b1},
      {OP_GAP,  17'h0,     8'h00, K_NONE, 1'b1},
      {OP_DONE, 17'h0,     8'h00, K_NONE, 1'b1}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [16:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        prog_done = 1'b0;
   logic [1:0]  wr_kind;
   logic        protect_on;
   logic        load_closed;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   wp_cmd_sequencer #(.ADDR_W(17), .DATA_W(8), .LOAD_GAP(GAP), .PROT_INIT(1'b0)) dut_i (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_valid    (wr_valid),
      .wr_addr     (wr_addr),
      .wr_data     (wr_data),
      .prog_done   (prog_done),
      .wr_kind     (wr_kind),
      .protect_on  (protect_on),
      .load_closed (load_closed)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Drive one cycle's inputs after a falling edge and settle before sampling.
   task automatic drive(input logic v, input logic [16:0] a, input logic [7:0] d,
                        input logic done);
      @(negedge clk);
      wr_valid  = v;
      wr_addr   = a;
      wr_data   = d;
      prog_done = done;
      #(CLK_PERIOD/4);
   endtask

   task automatic idle();
      drive(1'b0, 17'h0, 8'h00, 1'b0);
   endtask

   task automatic load(input string req, input logic [16:0] a, input logic [7:0] d,
                       input logic [1:0] exp_kind);
      drive(1'b1, a, d, 1'b0);
      check(req, int'(wr_kind), int'(exp_kind));
   endtask

   task automatic close_window(input string req);
      int seen = 0;
      for (int c = 0; c < GAP + 2; c++) begin
         idle();
         if (load_closed) seen++;
      end
      check(req, seen, 1);
   endtask

   task automatic period_end();
      drive(1'b0, 17'h0, 8'h00, 1'b1);
      idle();
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      errors++;
      $display("FAIL R8 watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // Reset state (R1)
      repeat (3) @(negedge clk);
      check("R1 protect during reset", int'(protect_on), 0);
      rst_n = 1'b1;
      idle();
      check("R1 kind idle", int'(wr_kind), int'(K_NONE));
      check("R1 protect after reset", int'(protect_on), 0);
      check("R1 closed after reset", int'(load_closed), 0);

      // Table walk
      for (int i = 0; i < NVEC; i++) begin
         logic [1:0]  op;
         logic [16:0] a;
         logic [7:0]  d;
         logic [1:0]  ek;
         logic        ep;
         {op, a, d, ek, ep} = VEC[i];
         case (op)
            OP_WR: begin
               load($sformatf("R2-table vec %0d kind", i), a, d, ek);
               idle();
            end
            OP_GAP:  close_window($sformatf("R8 vec %0d close pulse", i));
            default: period_end();
         endcase
         check($sformatf("R9 vec %0d protect", i), int'(protect_on), int'(ep));
      end

      // R8: a load in the expiry cycle keeps the window and the sequence alive
      load("R8 first key", 17'h05555, 8'hAA, K_CMD);
      for (int c = 1; c < GAP; c++) begin
         idle();
         check("R8 no early close", int'(load_closed), 0);
      end
      load("R8 load at expiry cycle", 17'h02AAA, 8'h55, K_CMD);
      check("R8 no close with load", int'(load_closed), 0);
      load("R8 prefix completes", 17'h05555, 8'hA0, K_CMD);
      for (int c = 1; c < GAP; c++) begin
         idle();
         check("R8 window still open", int'(load_closed), 0);
      end
      idle();
      check("R8 close exactly at gap", int'(load_closed), 1);
      period_end();
      check("R2 stays protected", int'(protect_on), 1);

      // R11: last disable byte meets a period end with nothing pending
      load("R11 dis 1", 17'h05555, 8'hAA, K_CMD);
      load("R11 dis 2", 17'h02AAA, 8'h55, K_CMD);
      load("R11 dis 3", 17'h05555, 8'h80, K_CMD);
      load("R11 dis 4", 17'h05555, 8'hAA, K_CMD);
      load("R11 dis 5", 17'h02AAA, 8'h55, K_CMD);
      drive(1'b1, 17'h05555, 8'h20, 1'b1);
      check("R11 dis 6 with done", int'(wr_kind), int'(K_CMD));
      load("R11 data after disable", 17'h00600, 8'h42, K_DAT);
      check("R11 clear waits", int'(protect_on), 1);
      close_window("R11 close");
      period_end();
      check("R11 clear applied later", int'(protect_on), 0);

      // R11: pending arm applied in the same cycle as an unkeyed load
      load("R11 arm 1", 17'h05555, 8'hAA, K_CMD);
      load("R11 arm 2", 17'h02AAA, 8'h55, K_CMD);
      load("R11 arm 3", 17'h05555, 8'hA0, K_CMD);
      close_window("R11 arm close");
      drive(1'b1, 17'h00700, 8'h01, 1'b1);
      check("R11 load sees old state", int'(wr_kind), int'(K_DAT));
      load("R11 next load rejected", 17'h00701, 8'h02, K_REJ);
      check("R11 protect set", int'(protect_on), 1);
      idle();

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule